// File: doc/BRIEF.md
# Completion Stream De-straddler

This block sits behind a wide completion receive path in which several packets can share a single data beat. Each beat arrives with a thermometer-coded start vector, a matching end vector, one slot pointer per start and one Dword offset per end. The block's input `tlast` and `tkeep` carry no information in this mode, so they are not inputs at all. Packet boundaries come only from the start and end fields.

The block cuts every packet segment out of the held input beat and shifts it so that its first Dword lands in lane 0. It then presents the segments one at a time on a plain valid/ready master with per-Dword keep, last and a discard marker. A packet that runs past the end of a beat is tracked across beats. Its continuation appears as the first segment of the next beat.

Malformed sideband raises a sticky protocol-error flag, and only reset clears it. The data width and the number of start slots are parameters: 1024 bits with 8 slots at full size, and 256 bits with 4 slots in the bench.

Top module: `cpl_destraddle`

## Requirements
- R1: After reset `out_valid` and `proto_err` are low, and no packet is open. With `in_valid` low, `out_valid` stays low.
- R2: Segments of a beat leave in order: first the open continuation (if any), then the starts by rising index. Output Dword i (bits 32i+31:32i) equals input Dword `start+i`, where start = start pointer × (DATA_W/32/SLOTS) Dwords.
- R3: `out_keep` bit i marks output Dword i. It is set contiguously from bit 0 up to (last Dword − first Dword). A segment with no end in the beat runs to the top Dword of the beat.
- R4: Segment j of a beat takes end-vector bit j as `out_last`, and end pointer j (a Dword offset in the beat) as its last Dword.
- R5: When a packet is open from an earlier beat, the first segment starts at Dword 0. It ends at end pointer 0, or runs to the top of the beat when end bit 0 is clear. Start pointer 0 then names the next packet.
- R6: `in_ready` is high only in the cycle the last segment of the beat is accepted downstream. A beat with no segment is accepted at once, with `out_valid` low.
- R7: While `out_valid` is high and `out_ready` low, the output holds its data, keep, last and discard values.
- R8: A packet remains open after a beat when (open-before + starts) exceeds the number of ends in that beat.
- R9: A start or end vector that is not of the form 0…01…1 (ones from bit 0 upward) sets `proto_err` when the beat is accepted.
- R10: Start pointer k (k counted from 0) below k sets `proto_err` when the beat is accepted.
- R11: `in_discont` is forwarded as `out_discont` on segment 0 when that segment ends. It sets `proto_err` if end bit 0 is clear, or if any packet starts after the discarded one in the same beat.
- R12: `proto_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat consumed |
| in_data | input | DATA_W | Straddled input beat |
| in_sop | input | SLOTS | Thermometer start vector |
| in_sop_ptr | input | SLOTS*SP_W | Start slot pointers, pointer k at bits k*SP_W |
| in_eop | input | SLOTS | Thermometer end vector |
| in_eop_ptr | input | SLOTS*EP_W | Last-Dword offsets, pointer k at bits k*EP_W |
| in_discont | input | 1 | Discard marker for the packet ending at end pointer 0 |
| out_valid | output | 1 | Output segment valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Realigned segment |
| out_keep | output | DATA_W/32 | Per-Dword valid mask |
| out_last | output | 1 | Segment ends its packet |
| out_discont | output | 1 | Packet must be discarded |
| proto_err | output | 1 | Sticky sideband violation |

## Verification
The hold assertion assumes the upstream side keeps the whole beat steady while `in_ready` is low. The bench drives each beat at a falling edge and changes it only after it has seen the beat accepted. The keep-shape assertion assumes each end offset is at or beyond its segment's start. The random generator builds each beat by walking free slots upward, so start slots rise and every end lies at or after its start. Discard is only ever set on a beat whose end bit 0 closes the final packet. Deliberately malformed beats are confined to directed cases that each end with a reset.

// File: rtl/dstr_pkg.sv
package dstr_pkg;

   localparam int DWORD_BITS = 32;
   localparam int VEC_MAX    = 64;

   // true when the vector is ones from bit 0 upward, then zeros
   function automatic logic thermo_ok(input logic [VEC_MAX-1:0] v);
      return (v & (v + 64'd1)) == '0;
   endfunction

endpackage

// File: rtl/dstr_sb_decode.sv
module dstr_sb_decode #(
   parameter int SLOTS = 8,
   parameter int SP_W  = 3,
   parameter int SEG_W = 4
) (
   input  logic                  cont,
   input  logic [SLOTS-1:0]      sop,
   input  logic [SLOTS*SP_W-1:0] sop_ptr,
   input  logic [SLOTS-1:0]      eop,
   input  logic                  discont,
   output logic [SEG_W-1:0]      nseg,
   output logic                  cont_next,
   output logic                  viol
);
   logic [SEG_W-1:0] nsop, nend;
   logic             ptr_low, disc_bad, shape_bad, end_excess;

   always_comb begin
      nsop    = '0;
      nend    = '0;
      ptr_low = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
         nsop = nsop + SEG_W'(sop[k]);
         nend = nend + SEG_W'(eop[k]);
         if (sop[k] && (sop_ptr[k*SP_W +: SP_W] < SP_W'(k)))
            ptr_low = 1'b1;
      end
   end

   assign nseg       = nsop + SEG_W'(cont);
   assign cont_next  = nseg > nend;
   assign shape_bad  = !dstr_pkg::thermo_ok(dstr_pkg::VEC_MAX'(sop)) ||
                       !dstr_pkg::thermo_ok(dstr_pkg::VEC_MAX'(eop));
   assign end_excess = nend > nseg;
   assign disc_bad   = discont && (!eop[0] || (nsop > SEG_W'(!cont)));
   assign viol       = shape_bad || ptr_low || disc_bad || end_excess;

endmodule

// File: rtl/dstr_seg_pick.sv
module dstr_seg_pick #(
   parameter int SLOTS = 8,
   parameter int SP_W  = 3,
   parameter int EP_W  = 5,
   parameter int SEG_W = 4
) (
   input  logic                  cont,
   input  logic [SEG_W-1:0]      seg_idx,
   input  logic [SLOTS*SP_W-1:0] sop_ptr,
   input  logic [SLOTS-1:0]      eop,
   input  logic [SLOTS*EP_W-1:0] eop_ptr,
   output logic [SP_W-1:0]       slot,
   output logic [EP_W-1:0]       end_dw,
   output logic                  ends
);
   // segment j pairs with end entry j; start entry is j minus the open packet
   always_comb begin
      slot   = '0;
      end_dw = '1;
      ends   = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (SEG_W'(i) + SEG_W'(cont) == seg_idx)
            slot = sop_ptr[i*SP_W +: SP_W];
         if (SEG_W'(i) == seg_idx) begin
            ends = eop[i];
            if (eop[i])
               end_dw = eop_ptr[i*EP_W +: EP_W];
         end
      end
   end

endmodule

// File: rtl/dstr_realign.sv
module dstr_realign #(
   parameter int DATA_W = 1024,
   parameter int SLOTS  = 8,
   parameter int SP_W   = 3,
   parameter int EP_W   = 5,
   parameter int STYLE  = 0
) (
   input  logic [DATA_W-1:0]    data,
   input  logic [SP_W-1:0]      slot,
   input  logic [EP_W-1:0]      len_m1,
   output logic [DATA_W-1:0]    odata,
   output logic [DATA_W/32-1:0] keep
);
   localparam int DW        = DATA_W / dstr_pkg::DWORD_BITS;
   localparam int SLOT_BITS = DATA_W / SLOTS;

   generate
      if (STYLE == 0) begin : g_log
         logic [DATA_W-1:0] stg [SP_W+1];
         assign stg[0] = data;
         for (genvar b = 0; b < SP_W; b++) begin : g_st
            localparam int SH = SLOT_BITS << b;
            assign stg[b+1] = slot[b] ? (stg[b] >> SH) : stg[b];
         end
         assign odata = stg[SP_W];
      end else begin : g_mux
         always_comb begin
            odata = data;
            for (int i = 0; i < SLOTS; i++)
               if (slot == SP_W'(i))
                  odata = data >> (i * SLOT_BITS);
         end
      end
   endgenerate

   always_comb
      for (int i = 0; i < DW; i++)
         keep[i] = EP_W'(i) <= len_m1;

endmodule

// File: rtl/cpl_destraddle.sv
module cpl_destraddle #(
   parameter int DATA_W      = 1024,
   parameter int SLOTS       = 8,
   parameter int SP_W        = $clog2(SLOTS),
   parameter int EP_W        = $clog2(DATA_W / 32),
   parameter int ALIGN_STYLE = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [DATA_W-1:0]     in_data,
   input  logic [SLOTS-1:0]      in_sop,
   input  logic [SLOTS*SP_W-1:0] in_sop_ptr,
   input  logic [SLOTS-1:0]      in_eop,
   input  logic [SLOTS*EP_W-1:0] in_eop_ptr,
   input  logic                  in_discont,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [DATA_W-1:0]     out_data,
   output logic [DATA_W/32-1:0]  out_keep,
   output logic                  out_last,
   output logic                  out_discont,
   output logic                  proto_err
);
   localparam int DW      = DATA_W / dstr_pkg::DWORD_BITS;
   localparam int SLOT_DW = DW / SLOTS;
   localparam int SLOT_SH = $clog2(SLOT_DW);
   localparam int SEG_W   = $clog2(SLOTS + 2);

   generate
      if (DATA_W % dstr_pkg::DWORD_BITS != 0 || DW % SLOTS != 0)
         begin : g_bad_div  $error("DATA_W must hold whole Dwords per slot"); end
      if (SLOTS < 2 || (1 << SP_W) != SLOTS || SLOTS > dstr_pkg::VEC_MAX)
         begin : g_bad_slots  $error("SLOTS must be a power of two, 2..64"); end
      if (SLOT_DW < 2 || (1 << SLOT_SH) != SLOT_DW)
         begin : g_bad_slotdw  $error("slot width must be a power-of-two Dword count >= 2"); end
      if (EP_W != $clog2(DW))
         begin : g_bad_epw  $error("EP_W must address every Dword"); end
      if (ALIGN_STYLE != 0 && ALIGN_STYLE != 1)
         begin : g_bad_style  $error("ALIGN_STYLE must be 0 or 1"); end
   endgenerate

   logic             open_q;
   logic [SEG_W-1:0] seg_q;
   logic             err_q;

   logic [SEG_W-1:0] nseg;
   logic             cont_next, viol;
   logic [SP_W-1:0]  slot;
   logic [EP_W-1:0]  end_dw, start_dw, len_m1;
   logic             ends, last_seg, take_in, take_out;

   dstr_sb_decode #(.SLOTS(SLOTS), .SP_W(SP_W), .SEG_W(SEG_W)) u_dec (
      .cont(open_q), .sop(in_sop), .sop_ptr(in_sop_ptr), .eop(in_eop),
      .discont(in_discont), .nseg(nseg), .cont_next(cont_next), .viol(viol)
   );

   dstr_seg_pick #(.SLOTS(SLOTS), .SP_W(SP_W), .EP_W(EP_W), .SEG_W(SEG_W)) u_pick (
      .cont(open_q), .seg_idx(seg_q), .sop_ptr(in_sop_ptr), .eop(in_eop),
      .eop_ptr(in_eop_ptr), .slot(slot), .end_dw(end_dw), .ends(ends)
   );

   assign start_dw = {slot, {SLOT_SH{1'b0}}};
   assign len_m1   = end_dw - start_dw;

   dstr_realign #(.DATA_W(DATA_W), .SLOTS(SLOTS), .SP_W(SP_W), .EP_W(EP_W),
                  .STYLE(ALIGN_STYLE)) u_align (
      .data(in_data), .slot(slot), .len_m1(len_m1), .odata(out_data), .keep(out_keep)
   );

   assign last_seg    = seg_q == nseg - SEG_W'(1);
   assign out_valid   = in_valid && (nseg != '0);
   assign in_ready    = (nseg == '0) || (out_ready && last_seg);
   assign take_in     = in_valid && in_ready;
   assign take_out    = out_valid && out_ready;
   assign out_last    = ends;
   assign out_discont = out_valid && in_discont && (seg_q == '0) && ends;
   assign proto_err   = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         seg_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         if (take_in) begin
            open_q <= cont_next;
            seg_q  <= '0;
            if (viol)
               err_q <= 1'b1;
         end else if (take_out) begin
            seg_q <= seg_q + SEG_W'(1);
         end
      end
   end

   // R1: nothing leaves while no beat is offered
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> !out_valid);

   // R3: keep is a run of ones from lane 0
   p_keep_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_keep[0] && ((out_keep & (out_keep + DW'(1))) == '0));

   // R6: beat is released only together with a downstream acceptance
   p_release_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && out_valid) |-> out_ready);

   // R7: stalled output holds
   p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
      $stable(out_keep) && $stable(out_last) && $stable(out_discont));

   // R11: discard marker only on a packet's final segment
   p_discont_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_discont |-> out_last);

   // R12: error flag never drops outside reset
   p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

endmodule

// File: tb/test_cpl_destraddle.sv
module test_cpl_destraddle;
   localparam int DATA_W = 256;
   localparam int SLOTS  = 4;
   localparam int SP_W   = 2;
   localparam int EP_W   = 3;
   localparam int DW     = 8;
   localparam int SD     = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                  in_valid = 1'b0, out_ready = 1'b0;
   logic                  in_ready, out_valid, out_last, out_discont, proto_err;
   logic [DATA_W-1:0]     in_data, out_data;
   logic [SLOTS-1:0]      in_sop, in_eop;
   logic [SLOTS*SP_W-1:0] in_sop_ptr;
   logic [SLOTS*EP_W-1:0] in_eop_ptr;
   logic                  in_discont;
   logic [DW-1:0]         out_keep;

   logic [DATA_W-1:0] b_data;
   logic [SLOTS-1:0]  b_sop, b_eop;
   int                b_sptr [SLOTS];
   int                b_eptr [SLOTS];
   logic              b_disc;
   bit                exp_cont;
   int                n_chk = 0, n_err = 0;

   always_comb begin
      in_data    = b_data;
      in_sop     = b_sop;
      in_eop     = b_eop;
      in_discont = b_disc;
      for (int k = 0; k < SLOTS; k++) begin
         in_sop_ptr[k*SP_W +: SP_W] = SP_W'(b_sptr[k]);
         in_eop_ptr[k*EP_W +: EP_W] = EP_W'(b_eptr[k]);
      end
   end

   cpl_destraddle #(.DATA_W(DATA_W), .SLOTS(SLOTS), .SP_W(SP_W), .EP_W(EP_W),
                    .ALIGN_STYLE(0)) i_cpl_destraddle (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_sop_ptr(in_sop_ptr), .in_eop(in_eop),
      .in_eop_ptr(in_eop_ptr), .in_discont(in_discont), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
      .out_last(out_last), .out_discont(out_discont), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int ones(input logic [SLOTS-1:0] v);
      int c = 0;
      for (int i = 0; i < SLOTS; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic clear_beat();
      b_sop = '0; b_eop = '0; b_disc = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin b_sptr[k] = 0; b_eptr[k] = 0; end
      for (int i = 0; i < DW; i++) b_data[i*32 +: 32] = $urandom;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; exp_cont = 1'b0;
   endtask

   // expected segment s of the current beat, compared against the ports
   task automatic check_seg(input int s, input string dtag);
      int st, en, len;
      bit e;
      logic [DATA_W-1:0] exp_d, mask, act_d;
      logic [DW-1:0] exp_k;
      st = (exp_cont && s == 0) ? 0 : b_sptr[s - int'(exp_cont)] * SD;
      e  = (s < SLOTS) ? b_eop[s] : 1'b0;
      en = e ? b_eptr[s] : DW - 1;
      len = en - st + 1;
      exp_d = '0; mask = '0; exp_k = '0;
      for (int i = 0; i < len; i++) begin
         exp_d[i*32 +: 32] = b_data[(st+i)*32 +: 32];
         mask[i*32 +: 32]  = '1;
         exp_k[i] = 1'b1;
      end
      act_d = out_data & mask;
      chk(out_valid == 1'b1, "R2", DATA_W'(out_valid), 1);
      chk(act_d == exp_d, dtag, act_d, exp_d);
      chk(out_keep == exp_k, "R3", DATA_W'(out_keep), DATA_W'(exp_k));
      chk(out_last == e, "R4", DATA_W'(out_last), DATA_W'(e));
      chk(out_discont == (b_disc && s == 0 && e), "R11", DATA_W'(out_discont),
          DATA_W'(b_disc && s == 0 && e));
   endtask

   task automatic run_beat(input int rdy_pct);
      int n, s, guard;
      bit stalled;
      string tag;
      @(negedge clk);
      in_valid = 1'b1;
      n = int'(exp_cont) + ones(b_sop);
      s = 0; guard = 0; stalled = 0;
      forever begin
         out_ready = (($urandom % 100) < rdy_pct);
         #1;
         if (n == 0) begin
            chk(in_ready == 1'b1, "R6", DATA_W'(in_ready), 1);
            chk(out_valid == 1'b0, "R6", DATA_W'(out_valid), 0);
            @(posedge clk);
            break;
         end
         tag = stalled ? "R7" : ((exp_cont && s == 0) ? "R5" : "R2");
         check_seg(s, tag);
         chk(in_ready == (out_ready && s == n - 1), "R6", DATA_W'(in_ready),
             DATA_W'(out_ready && s == n - 1));
         @(posedge clk);
         stalled = !out_ready;
         if (out_ready) s++;
         if (s == n) break;
         guard++;
         if (guard > 200) begin chk(0, "R6", 0, 1); break; end
         @(negedge clk);
      end
      exp_cont = n > ones(b_eop);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // malformed beat: drain with ready high, no data comparison
   task automatic run_raw();
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1;
      for (int g = 0; g < 20; g++) begin
         #1;
         if (in_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic gen_beat();
      int slot, k, ei, st, en;
      clear_beat();
      slot = 0; k = 0; ei = 0;
      if (exp_cont) begin
         if ($urandom % 4 == 0) return;
         en = int'($urandom % DW);
         b_eop[0] = 1'b1; b_eptr[0] = en; ei = 1;
         slot = en / SD + 1;
      end
      while (slot < SLOTS) begin
         if ($urandom % 3 == 0) begin slot++; continue; end
         b_sop[k] = 1'b1; b_sptr[k] = slot; k++;
         st = slot * SD;
         if ($urandom % 4 == 0) break;
         en = st + int'($urandom % (DW - st));
         b_eop[ei] = 1'b1; b_eptr[ei] = en; ei++;
         slot = en / SD + 1;
      end
      if (b_eop[0] && ones(b_sop) == (exp_cont ? 0 : 1) && ($urandom % 4 == 0))
         b_disc = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      exp_cont = 1'b0;
      clear_beat();
      do_reset();
      #1;
      chk(out_valid == 1'b0, "R1", DATA_W'(out_valid), 0);
      chk(proto_err == 1'b0, "R1", DATA_W'(proto_err), 0);

      // empty beat, nothing open
      clear_beat(); run_beat(100);

      // four packets in one beat, each one slot long
      clear_beat();
      b_sop = 4'b1111; b_eop = 4'b1111;
      for (int k = 0; k < 4; k++) begin b_sptr[k] = k; b_eptr[k] = 2*k + 1; end
      run_beat(100);

      // start in slot 2 that continues, then ends at Dword 4 next to a new start
      clear_beat(); b_sop = 4'b0001; b_sptr[0] = 2; run_beat(60);
      chk(exp_cont == 1'b1, "R8", DATA_W'(exp_cont), 1);
      clear_beat(); b_sop = 4'b0001; b_sptr[0] = 3; b_eop = 4'b0011;
      b_eptr[0] = 4; b_eptr[1] = 7; run_beat(60);

      // open packet through a full beat, then through another
      clear_beat(); b_sop = 4'b0001; b_sptr[0] = 0; run_beat(100);
      clear_beat(); run_beat(40);
      clear_beat(); b_eop = 4'b0001; b_eptr[0] = 0; run_beat(100);

      for (int r = 0; r < 500; r++) begin
         gen_beat();
         run_beat(r < 100 ? 100 : 65);
      end
      #1;
      chk(proto_err == 1'b0, "R9", DATA_W'(proto_err), 0);

      // discard forwarded, legal
      if (exp_cont) begin clear_beat(); b_eop = 4'b0001; b_eptr[0] = 7; run_beat(100); end
      clear_beat(); b_sop = 4'b0001; b_eop = 4'b0001; b_eptr[0] = 5; b_disc = 1'b1;
      run_beat(100);
      #1;
      chk(proto_err == 1'b0, "R11", DATA_W'(proto_err), 0);

      // reserved start vector
      clear_beat(); b_sop = 4'b0101; b_sptr[0] = 0; b_sptr[2] = 3; run_raw();
      #1;
      chk(proto_err == 1'b1, "R9", DATA_W'(proto_err), 1);
      clear_beat(); run_raw();
      repeat (3) @(negedge clk);
      #1;
      chk(proto_err == 1'b1, "R12", DATA_W'(proto_err), 1);
      do_reset(); #1;
      chk(proto_err == 1'b0, "R1", DATA_W'(proto_err), 0);

      // reserved end vector
      clear_beat(); b_sop = 4'b0001; b_eop = 4'b0010; b_eptr[1] = 3; run_raw();
      #1;
      chk(proto_err == 1'b1, "R9", DATA_W'(proto_err), 1);
      do_reset();

      // start pointer 1 below its minimum
      clear_beat(); b_sop = 4'b0011; b_sptr[0] = 0; b_sptr[1] = 0;
      b_eop = 4'b0011; b_eptr[0] = 1; b_eptr[1] = 3; run_raw();
      #1;
      chk(proto_err == 1'b1, "R10", DATA_W'(proto_err), 1);
      do_reset();

      // discard followed by another start in the same beat
      clear_beat(); b_sop = 4'b0011; b_sptr[0] = 0; b_sptr[1] = 2;
      b_eop = 4'b0011; b_eptr[0] = 1; b_eptr[1] = 5; b_disc = 1'b1; run_raw();
      #1;
      chk(proto_err == 1'b1, "R11", DATA_W'(proto_err), 1);
      do_reset();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule